// File: doc/BRIEF.md
# Clock Source Mode Controller

This block manages where the system clock comes from. It chooses between a direct reference input, which a low-frequency crystal oscillator or an external source can drive, and the output of a PLL whose analog parts sit outside the block. It drives enable lines for the crystal oscillator and the VCO. It also holds the PLL's 8-bit feedback divisor and its 2-bit output-tap select, and presents both to the analog side.

Software controls the block through one 16-bit register, written and read in the reference clock domain. A settle timer restarts whenever the VCO is enabled again. A request to run from the PLL is held off until that timer has counted out. The switch between the two clocks goes through a handshake in each clock domain. The old clock is gated off while it is low, and only then is the new clock gated on, so no shortened pulse reaches the output.

Top module: `clk_source_ctrl`

## Requirements
- R1: After reset the register reads back `{DIV_RST, 8'h00}` plus only the ready bit once settled. Bit 0 is the PLL select request, bit 1 is stop-VCO, bit 2 is stop-crystal, bits 4:3 are the tap select, bit 5 is PLL ready, bit 6 is PLL active, bit 7 reads 0 and bits 15:8 are the feedback divisor. In this state `xtal_en`=1, `vco_en`=1 and `sys_clk` follows `ref_clk`.
- R2: A write with `wr_en`=1 on a `ref_clk` rising edge stores bits 0 to 4 and 15:8 of `wr_data`, and those values read back after that edge. Bits 7:5 of the write are ignored.
- R3: PLL ready (bit 5) rises on the SETTLE_CYC-th `ref_clk` rising edge after reset release, or after the edge on which `vco_en` rises. While `vco_en` is 0 it reads 0, and the count restarts from zero each time the VCO is enabled again.
- R4: While PLL ready is 0, setting the select request leaves `sys_clk` on `ref_clk` and PLL active (bit 6) stays 0.
- R5: With the select request at 1, ready at 1 and stop-VCO at 0, the output moves to `vco_clk` within a few cycles and PLL active reads 1. Clearing the select request returns the output to `ref_clk` and PLL active reads 0.
- R6: `sys_clk` never shows a high or a low phase shorter than the shorter half period of the two input clocks, and the two clock gates are never open at the same time.
- R7: Stop-VCO takes `vco_en` to 0 on the second `ref_clk` edge after the write when the PLL is not active. When the write arrives while running from the PLL, the output first returns to `ref_clk`, and `vco_en` falls only after PLL active reads 0.
- R8: Stop-crystal with the select request at 0 and the PLL inactive is accepted: `xtal_en`=0. A select request of 1 forces `xtal_en`=1 whatever the stop-crystal bit holds.
- R9: `post_sel` and `fb_div` always equal the stored tap-select and divisor fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Direct reference clock (crystal or external) |
| vco_clk | input | 1 | PLL output clock after the tap select |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, `ref_clk` domain |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register readback with status bits |
| xtal_en | output | 1 | Crystal oscillator enable |
| vco_en | output | 1 | VCO enable |
| post_sel | output | 2 | VCO output tap select |
| fb_div | output | 8 | PLL feedback divisor |
| sys_clk | output | 1 | Glitch-free system clock |

## Verification
The hardest situation to reach is a stop-VCO write that arrives while the output is running from the PLL. The handshake must first complete back to the reference clock, and only then may the VCO enable fall. The bench gets there by reaching PLL mode the normal way first: it waits for ready, then for the active bit. It then writes stop-VCO with the select request still set, and watches every cycle for `vco_en` falling while the active bit is still 1. An earlier request made before ready covers the hold-off case. A re-enable covers the timer restart.

// File: rtl/clk_source_ctrl.sv
module clk_source_ctrl #(
  parameter int         SETTLE_CYC = 328,
  parameter logic [7:0] DIV_RST    = 8'd244
) (
  input  logic        ref_clk,
  input  logic        vco_clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  output logic        xtal_en,
  output logic        vco_en,
  output logic [1:0]  post_sel,
  output logic [7:0]  fb_div,
  output logic        sys_clk
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] CNT_DONE = CW'(SETTLE_CYC);

  logic          sel_req, vco_stop, xtal_stop;
  logic [1:0]    tap;
  logic [7:0]    div;
  logic          vco_on;
  logic [CW-1:0] cnt;
  logic          ready, want_pll;
  logic          ref_s0, ref_s1, ref_g;
  logic          vco_s0, vco_s1, pll_g;
  logic          act_s0, act_s1;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      sel_req   <= 1'b0;
      vco_stop  <= 1'b0;
      xtal_stop <= 1'b0;
      tap       <= 2'b00;
      div       <= DIV_RST;
    end else if (wr_en) begin
      sel_req   <= wr_data[0];
      vco_stop  <= wr_data[1];
      xtal_stop <= wr_data[2];
      tap       <= wr_data[4:3];
      div       <= wr_data[15:8];
    end

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) vco_on <= 1'b1;
    else        vco_on <= ~vco_stop | act_s1 | ~ref_g;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n)            cnt <= '0;
    else if (!vco_on)      cnt <= '0;
    else if (cnt != CNT_DONE) cnt <= cnt + 1'b1;

  assign ready    = vco_on && (cnt == CNT_DONE);
  assign want_pll = sel_req & ready & ~vco_stop;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) {ref_s0, ref_s1} <= 2'b11;
    else begin
      ref_s0 <= ~want_pll & ~pll_g;
      ref_s1 <= ref_s0;
    end

  always_ff @(negedge ref_clk or negedge rst_n)
    if (!rst_n) ref_g <= 1'b1;
    else        ref_g <= ref_s1;

  always_ff @(posedge vco_clk or negedge rst_n)
    if (!rst_n) {vco_s0, vco_s1} <= 2'b00;
    else begin
      vco_s0 <= want_pll & ~ref_g;
      vco_s1 <= vco_s0;
    end

  always_ff @(negedge vco_clk or negedge rst_n)
    if (!rst_n) pll_g <= 1'b0;
    else        pll_g <= vco_s1;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) {act_s0, act_s1} <= 2'b00;
    else begin
      act_s0 <= pll_g;
      act_s1 <= act_s0;
    end

  assign sys_clk  = (ref_clk & ref_g) | (vco_clk & pll_g);
  assign xtal_en  = ~xtal_stop | sel_req | act_s1;
  assign vco_en   = vco_on;
  assign post_sel = tap;
  assign fb_div   = div;
  assign rd_data  = {div, 1'b0, act_s1, ready, tap, xtal_stop, vco_stop, sel_req};

  AST_GATE_EXCL: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !(ref_g && pll_g)); // R6

  AST_PLL_AFTER_SETTLE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    pll_g |-> (cnt == CNT_DONE) && vco_on); // R4

  AST_VCO_AFTER_RETURN: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !vco_on |-> !pll_g && !act_s1); // R7

  AST_SETTLE_RESTART: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(vco_on) |-> (cnt == '0) && !ready); // R3

  AST_TAP_FOLLOWS: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $past(wr_en) |-> post_sel == $past(wr_data[4:3])); // R9
endmodule

// File: tb/clk_source_ctrl_tb.sv
`timescale 1ns/1ps
module clk_source_ctrl_tb;
  localparam int S = 24;
  localparam logic [7:0] DR = 8'd244;

  logic ref_clk = 0, vco_clk = 0, rst_n = 0, wr_en = 0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic xtal_en, vco_en, sys_clk;
  logic [1:0] post_sel;
  logic [7:0] fb_div;

  int checks = 0, errors = 0;
  bit skip_vco = 0, done = 0;

  always #2   ref_clk = ~ref_clk;
  always #1.5 vco_clk = ~vco_clk;

  clk_source_ctrl #(.SETTLE_CYC(S), .DIV_RST(DR)) u_dut (
    .ref_clk(ref_clk), .vco_clk(vco_clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .xtal_en(xtal_en), .vco_en(vco_en),
    .post_sel(post_sel), .fb_div(fb_div), .sys_clk(sys_clk));

  // behavioural reference model
  logic [15:0] m_cfg;
  bit m_ven;
  int m_cnt;
  always @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      m_cfg <= {DR, 8'h00}; m_ven <= 1; m_cnt <= 0;
    end else begin
      m_ven <= !m_cfg[1];
      if (!m_ven) m_cnt <= 0; else if (m_cnt < S) m_cnt <= m_cnt + 1;
      if (wr_en) m_cfg <= {wr_data[15:8], 3'b000, wr_data[4:0]};
    end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge ref_clk) if (rst_n && !done) begin
    #1;
    chk(rd_data[4:0] == m_cfg[4:0] && rd_data[15:8] == m_cfg[15:8] && !rd_data[7],
        "R2", rd_data, m_cfg);
    chk(post_sel == m_cfg[4:3] && fb_div == m_cfg[15:8], "R9", {fb_div, post_sel}, {m_cfg[15:8], m_cfg[4:3]});
    if (!skip_vco) begin
      chk(rd_data[5] == (m_ven && m_cnt == S), "R3", rd_data[5], m_ven && m_cnt == S);
      chk(vco_en == m_ven, "R7", vco_en, m_ven);
    end
    if (!rd_data[6])
      chk(xtal_en == (!m_cfg[2] || m_cfg[0]), "R8", xtal_en, !m_cfg[2] || m_cfg[0]);
  end

  // pulse width monitor
  realtime last_t = 0;
  int edges = 0;
  always @(sys_clk) begin
    if (rst_n && last_t > 0 && ($realtime - last_t) < 1.4) begin
      errors++; checks++;
      $display("FAIL R6 actual=%0t expected>=1.4ns", $realtime - last_t);
    end
    last_t = $realtime;
  end
  always @(posedge sys_clk) edges++;

  task automatic wr(input logic [15:0] d);
    @(negedge ref_clk); wr_en = 1; wr_data = d;
    @(negedge ref_clk); wr_en = 0;
  endtask

  task automatic freq(input bit on_pll, input string req);
    int e0;
    e0 = edges; #40;
    if (on_pll) chk(edges - e0 >= 12 && edges - e0 <= 15, req, edges - e0, 13);
    else        chk(edges - e0 >= 9 && edges - e0 <= 11, req, edges - e0, 10);
  endtask

  task automatic wait_act(input bit v, input string req);
    int n = 0;
    while (rd_data[6] != v && n < 40) begin @(posedge ref_clk); #1; n++; end
    chk(rd_data[6] == v, req, rd_data[6], v);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge ref_clk);
    rst_n = 1;
    @(posedge ref_clk); #1;
    chk(rd_data == {DR, 8'h00}, "R1", rd_data, {DR, 8'h00});
    chk(xtal_en && vco_en, "R1", {xtal_en, vco_en}, 2'b11);
    freq(0, "R1");
    wr({DR, 8'h01});                        // request PLL before ready
    freq(0, "R4");
    chk(rd_data[6] == 0, "R4", rd_data[6], 0);
    wait_act(1, "R5");
    freq(1, "R5");
    wr({8'd37, 8'h11});                     // tap 2, new divisor, still PLL
    chk(post_sel == 2'b10 && fb_div == 8'd37, "R9", {fb_div, post_sel}, {8'd37, 2'b10});
    wr({8'd37, 8'hE0});                     // back to direct, ignored bits set
    wait_act(0, "R5");
    freq(0, "R5");
    wr({8'd37, 8'h02});                     // stop VCO while direct
    repeat (4) @(posedge ref_clk); #1;
    chk(vco_en == 0 && rd_data[5] == 0, "R7", {vco_en, rd_data[5]}, 0);
    wr({8'd37, 8'h01});                     // re-enable, request PLL
    repeat (S / 2) @(posedge ref_clk);
    freq(0, "R4");
    wait_act(1, "R3");
    wr({8'd37, 8'h03});                     // stop VCO while on PLL
    skip_vco = 1;
    for (int i = 0; i < 40; i++) begin
      @(posedge ref_clk); #1;
      chk(vco_en || !rd_data[6], "R7", {vco_en, rd_data[6]}, 2'b00);
    end
    chk(vco_en == 0 && rd_data[6] == 0, "R7", {vco_en, rd_data[6]}, 0);
    freq(0, "R7");
    skip_vco = 0;
    wr({8'd37, 8'h04});                     // external direct: xtal stopped
    repeat (2) @(posedge ref_clk); #1;
    chk(xtal_en == 0, "R8", xtal_en, 0);
    wr({8'd37, 8'h05});
    repeat (2) @(posedge ref_clk); #1;
    chk(xtal_en == 1, "R8", xtal_en, 1);
    repeat (S + 20) @(posedge ref_clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule